// File: doc/BRIEF.md
# DSP Core Run Control Gate

This block sits between a host register bus and a small embedded DSP core. One control register holds a core-enable level and a start trigger. The block turns these into an enable level for the core and a one-cycle start pulse. It also gates host access to the core's program and data memory. A memory access reaches the memory only while the core is held off. While the core runs, the access is refused with an error response.

A second register holds the audio-path enable bits. A request that would switch on a path is refused while the core is not enabled. A refused request leaves the register unchanged and sets a sticky error bit. When the core is turned off, the block raises a request telling software to return every DMA channel enable and the write-DMA buffer length to zero. Software clears that request once it has done so.

Register offsets are 0 for control, 1 for path enables and 2 for status. Offset 3 reads as zero and ignores writes.

Top module: `dspg_run_gate`

## Requirements
- R1: After reset, core_en, core_start, path_en, path_err and dma_clr_req are 0, and all three registers read as 0.
- R2: Writing offset 0 loads bit 1 into core_en on the next cycle. Bit 1 of offset 0 reads back that level.
- R3: A write to offset 0 with bit 0 = 1 and bit 1 = 1 gives core_start = 1 for exactly the next cycle, whether or not core_en was already 1. Bit 0 of offset 0 always reads 0.
- R4: A write to offset 0 with bit 0 = 1 and bit 1 = 0 produces no start pulse.
- R5: While core_en = 0, a memory access with mem_req = 1 drives fw_req = 1 and passes mem_we on to fw_we. It returns fw_rdata on mem_rdata with mem_err = 0, in the same cycle.
- R6: While core_en = 1, a memory access gives fw_req = 0, fw_we = 0, mem_err = 1 and mem_rdata = 0.
- R7: While core_en = 0, a write to offset 1 that would set a path bit that is currently 0 is rejected. path_en stays unchanged and path_err (status bit 0) becomes 1. A write that only clears bits is accepted.
- R8: While core_en = 1, any write to offset 1 loads its low NP bits into path_en.
- R9: path_err stays at 1 until a status write with bit 0 = 1 clears it.
- R10: A 1-to-0 change of core_en sets dma_clr_req (status bit 1). A status write with bit 1 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| core_en | output | 1 | Firmware execution enable level |
| core_start | output | 1 | One-cycle firmware start pulse |
| mem_req | input | 1 | Host memory access request |
| mem_we | input | 1 | Host memory access is a write |
| mem_addr | input | MAW | Host memory word address |
| mem_wdata | input | MDW | Host memory write data |
| mem_rdata | output | MDW | Host memory read data, 0 when blocked |
| mem_err | output | 1 | Access refused because the core is enabled |
| fw_req | output | 1 | Granted request to firmware memory |
| fw_we | output | 1 | Granted write to firmware memory |
| fw_addr | output | MAW | Address to firmware memory |
| fw_wdata | output | MDW | Write data to firmware memory |
| fw_rdata | input | MDW | Read data from firmware memory |
| path_en | output | NP | Audio-path enable bits |
| path_err | output | 1 | Sticky rejected-path-enable flag |
| dma_clr_req | output | 1 | DMA cleanup needed after core disable |

## Verification
The start logic is driven with a start write while the core is off, with start and enable written together, and with a start write while the core already runs. Together these separate a pulse keyed to the written enable bit from one keyed to the stored bit or to the start bit alone. Path writes are issued with the core off in two forms: one sets a new bit and one only clears bits. A second set is issued with the core on. This shows that rejection depends on new bits and on the core level, not on any write to the register. Memory reads and writes are issued with the core both off and on, and the error, grant and zeroed read data are checked in the same cycle. Disabling the core followed by selective status clears shows that the two sticky flags are independent.

// File: rtl/dspg_pkg.sv
`timescale 1ns/1ps
package dspg_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_PATH = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_EN_BIT   = 1;
    localparam int STAT_PERR_BIT = 0;
    localparam int STAT_DMA_BIT  = 1;

    typedef struct packed {
        logic en;
        logic go;
    } ctrl_wr_t;

    typedef struct packed {
        logic perr_clr;
        logic dma_clr;
    } stat_wr_t;

    function automatic ctrl_wr_t unpack_ctrl(input logic en, input logic go);
        ctrl_wr_t c;
        c.en = en;
        c.go = go;
        return c;
    endfunction
endpackage

// File: rtl/dspg_ctrl_regs.sv
`timescale 1ns/1ps
module dspg_ctrl_regs
    import dspg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_ctrl,
    input  ctrl_wr_t ctrl_in,
    input  logic     wr_stat,
    input  stat_wr_t stat_in,
    output logic     core_en,
    output logic     core_start,
    output logic     dma_clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            core_en     <= 1'b0;
            core_start  <= 1'b0;
            dma_clr_req <= 1'b0;
        end else begin
            core_start <= wr_ctrl && ctrl_in.go && ctrl_in.en;
            if (wr_ctrl) begin
                core_en <= ctrl_in.en;
            end
            if (wr_ctrl && core_en && !ctrl_in.en) begin
                dma_clr_req <= 1'b1;
            end else if (wr_stat && stat_in.dma_clr) begin
                dma_clr_req <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dspg_path_guard.sv
`timescale 1ns/1ps
module dspg_path_guard #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_en,
    input  logic          wr_path,
    input  logic [NP-1:0] path_in,
    input  logic          perr_clr,
    output logic [NP-1:0] path_en,
    output logic          path_err
);
    logic adds_bits;
    logic refuse;

    always_comb begin
        adds_bits = |(path_in & ~path_en);
        refuse    = wr_path && !core_en && adds_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_en  <= '0;
            path_err <= 1'b0;
        end else begin
            if (wr_path && !refuse) begin
                path_en <= path_in;
            end
            if (refuse) begin
                path_err <= 1'b1;
            end else if (perr_clr) begin
                path_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dspg_mem_gate.sv
`timescale 1ns/1ps
module dspg_mem_gate #(
    parameter int MAW = 10,
    parameter int MDW = 24
) (
    input  logic           core_en,
    input  logic           mem_req,
    input  logic           mem_we,
    input  logic [MAW-1:0] mem_addr,
    input  logic [MDW-1:0] mem_wdata,
    output logic [MDW-1:0] mem_rdata,
    output logic           mem_err,
    output logic           fw_req,
    output logic           fw_we,
    output logic [MAW-1:0] fw_addr,
    output logic [MDW-1:0] fw_wdata,
    input  logic [MDW-1:0] fw_rdata
);
    logic granted;

    always_comb begin
        granted   = mem_req && !core_en;
        fw_req    = granted;
        fw_we     = granted && mem_we;
        fw_addr   = mem_addr;
        fw_wdata  = mem_wdata;
        mem_err   = mem_req && core_en;
        mem_rdata = granted ? fw_rdata : '0;
    end
endmodule

// File: rtl/dspg_run_gate.sv
`timescale 1ns/1ps
module dspg_run_gate
    import dspg_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NP  = 4,
    parameter int MAW = 10,
    parameter int MDW = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [1:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           core_en,
    output logic           core_start,
    input  logic           mem_req,
    input  logic           mem_we,
    input  logic [MAW-1:0] mem_addr,
    input  logic [MDW-1:0] mem_wdata,
    output logic [MDW-1:0] mem_rdata,
    output logic           mem_err,
    output logic           fw_req,
    output logic           fw_we,
    output logic [MAW-1:0] fw_addr,
    output logic [MDW-1:0] fw_wdata,
    input  logic [MDW-1:0] fw_rdata,
    output logic [NP-1:0]  path_en,
    output logic           path_err,
    output logic           dma_clr_req
);
    reg_addr_e ra;
    logic      wr_ctrl, wr_path, wr_stat;
    ctrl_wr_t  ctrl_in;
    stat_wr_t  stat_in;
    logic      unused_wbits;

    always_comb begin
        ra               = reg_addr_e'(reg_addr);
        wr_ctrl          = reg_we && (ra == RA_CTRL);
        wr_path          = reg_we && (ra == RA_PATH);
        wr_stat          = reg_we && (ra == RA_STAT);
        ctrl_in          = unpack_ctrl(reg_wdata[CTRL_EN_BIT], reg_wdata[CTRL_GO_BIT]);
        stat_in.perr_clr = reg_wdata[STAT_PERR_BIT];
        stat_in.dma_clr  = reg_wdata[STAT_DMA_BIT];
        unused_wbits     = ^reg_wdata;
    end

    dspg_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .ctrl_in     (ctrl_in),
        .wr_stat     (wr_stat),
        .stat_in     (stat_in),
        .core_en     (core_en),
        .core_start  (core_start),
        .dma_clr_req (dma_clr_req)
    );

    dspg_path_guard #(.NP(NP)) u_path (
        .clk      (clk),
        .rst      (rst),
        .core_en  (core_en),
        .wr_path  (wr_path),
        .path_in  (reg_wdata[NP-1:0]),
        .perr_clr (wr_stat && stat_in.perr_clr),
        .path_en  (path_en),
        .path_err (path_err)
    );

    dspg_mem_gate #(.MAW(MAW), .MDW(MDW)) u_mem (
        .core_en   (core_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .fw_req    (fw_req),
        .fw_we     (fw_we),
        .fw_addr   (fw_addr),
        .fw_wdata  (fw_wdata),
        .fw_rdata  (fw_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (ra)
            RA_CTRL: reg_rdata[CTRL_EN_BIT] = core_en;
            RA_PATH: reg_rdata[NP-1:0]      = path_en;
            RA_STAT: begin
                reg_rdata[STAT_PERR_BIT] = path_err;
                reg_rdata[STAT_DMA_BIT]  = dma_clr_req;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dspg_run_gate_chk.sv
`timescale 1ns/1ps
module dspg_run_gate_chk #(
    parameter int DW  = 8,
    parameter int NP  = 4,
    parameter int MDW = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_we,
    input logic [1:0]     reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic           core_en,
    input logic           core_start,
    input logic           mem_req,
    input logic [MDW-1:0] mem_rdata,
    input logic           mem_err,
    input logic           fw_req,
    input logic [NP-1:0]  path_en,
    input logic           path_err,
    input logic           dma_clr_req
);
    AST_START_WITH_EN: assert property (@(posedge clk) disable iff (rst)
        core_start |-> core_en); // R3
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        core_start |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata[0] && reg_wdata[1])); // R3
    AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        fw_req |-> !core_en); // R5
    AST_BLOCK_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && core_en) |-> (!fw_req && mem_err && mem_rdata == '0)); // R6
    AST_REFUSE_KEEPS_PATH: assert property (@(posedge clk) disable iff (rst)
        $rose(path_err) |-> $stable(path_en)); // R7
    AST_PATH_GROWS_WHEN_RUN: assert property (@(posedge clk) disable iff (rst)
        ($past(!core_en) && (|(path_en & ~$past(path_en)))) |-> $past(core_en)); // R7
    AST_DMA_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(core_en) |-> dma_clr_req); // R10
endmodule

bind dspg_run_gate dspg_run_gate_chk #(.DW(DW), .NP(NP), .MDW(MDW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .core_en     (core_en),
    .core_start  (core_start),
    .mem_req     (mem_req),
    .mem_rdata   (mem_rdata),
    .mem_err     (mem_err),
    .fw_req      (fw_req),
    .path_en     (path_en),
    .path_err    (path_err),
    .dma_clr_req (dma_clr_req)
);

// File: tb/sim_dspg_run_gate.sv
`timescale 1ns/1ps
module sim_dspg_run_gate;
    localparam int DW = 8, NP = 4, MAW = 10, MDW = 24;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic core_en, core_start;
    logic mem_req = 1'b0, mem_we = 1'b0;
    logic [MAW-1:0] mem_addr = '0, fw_addr;
    logic [MDW-1:0] mem_wdata = '0, mem_rdata, fw_wdata, fw_rdata;
    logic mem_err, fw_req, fw_we;
    logic [NP-1:0] path_en;
    logic path_err, dma_clr_req;

    int tests = 0, fails = 0;

    // behavioural reference state
    bit m_en, m_go, m_perr, m_dma;
    int m_path;

    always #4 clk = ~clk;

    assign fw_rdata = 24'hA50000 | MDW'(mem_addr);

    dspg_run_gate #(.DW(DW), .NP(NP), .MAW(MAW), .MDW(MDW)) u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_en ? 2 : 0;
            1: return m_path;
            2: return (m_dma ? 2 : 0) | (m_perr ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    // drive at negedge, compare shortly after, model advances at posedge
    task automatic step(input bit we, input int a, input int wd, input bit mr, input bit mw,
                        input int ma, input string tag);
        reg_we = we; reg_addr = 2'(a); reg_wdata = DW'(wd);
        mem_req = mr; mem_we = mw; mem_addr = MAW'(ma); mem_wdata = MDW'(ma * 3);
        #1;
        chk(tag, "core_en", int'(core_en), int'(m_en));
        chk(tag, "core_start", int'(core_start), int'(m_go));
        chk(tag, "path_en", int'(path_en), m_path);
        chk(tag, "path_err", int'(path_err), int'(m_perr));
        chk(tag, "dma_clr_req", int'(dma_clr_req), int'(m_dma));
        chk(tag, "reg_rdata", int'(reg_rdata), exp_rdata(a));
        chk(tag, "fw_req", int'(fw_req), int'(mr && !m_en));
        chk(tag, "fw_we", int'(fw_we), int'(mr && mw && !m_en));
        chk(tag, "mem_err", int'(mem_err), int'(mr && m_en));
        chk(tag, "mem_rdata", int'(mem_rdata), (mr && !m_en) ? (32'hA50000 | ma) : 0);
        if (mr && !m_en) chk(tag, "fw_addr", int'(fw_addr), ma);
        @(posedge clk);
        m_go = 0;
        if (we) begin
            case (a)
                0: begin
                    m_go = wd[0] && wd[1];
                    if (m_en && !wd[1]) m_dma = 1;
                    m_en = wd[1];
                end
                1: begin
                    if (m_en || ((wd & ~m_path & 32'hF) == 0)) m_path = wd & 32'hF;
                    else m_perr = 1;
                end
                2: begin
                    if (wd[0]) m_perr = 0;
                    if (wd[1]) m_dma = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_en = 0; m_go = 0; m_perr = 0; m_dma = 0; m_path = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, "R1 reset ctrl");
        step(0, 1, 0, 0, 0, 0, "R1 reset path");
        step(0, 2, 0, 0, 0, 0, "R1 reset stat");
        step(1, 1, 1, 0, 0, 0, "R7 set path while off");
        step(0, 2, 0, 0, 0, 0, "R7 sticky err visible");
        step(1, 2, 1, 0, 0, 0, "R9 clear err");
        step(0, 2, 0, 1, 0, 5, "R5 read while off");
        step(0, 0, 0, 1, 1, 9, "R5 write while off");
        step(1, 0, 1, 0, 0, 0, "R4 start without enable");
        step(0, 0, 0, 0, 0, 0, "R4 no pulse");
        step(1, 0, 3, 0, 0, 0, "R2 R3 enable and start");
        step(0, 0, 0, 0, 0, 0, "R3 pulse cycle");
        step(0, 0, 0, 1, 0, 7, "R6 read while running");
        step(0, 0, 0, 1, 1, 8, "R6 write while running");
        step(1, 1, 5, 0, 0, 0, "R8 path set while running");
        step(1, 0, 3, 0, 0, 0, "R3 restart while running");
        step(0, 1, 0, 0, 0, 0, "R3 second pulse");
        step(1, 0, 0, 0, 0, 0, "R10 disable core");
        step(0, 2, 0, 0, 0, 0, "R10 flag raised");
        step(1, 1, 1, 0, 0, 0, "R7 clear-only accepted");
        step(1, 1, 3, 0, 0, 0, "R7 new bit refused");
        step(0, 1, 0, 0, 0, 0, "R7 path held");
        step(1, 2, 2, 0, 0, 0, "R10 clear dma flag only");
        step(0, 2, 0, 0, 0, 0, "R9 err still held");
        step(1, 3, 8'hFF, 0, 0, 0, "R1 unused offset");
        step(0, 3, 0, 1, 0, 3, "R5 after disable");
        step(1, 2, 3, 0, 0, 0, "R9 R10 clear both");
        step(0, 2, 0, 0, 0, 0, "R9 cleared");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule